// File: doc/BRIEF.md
# Bit-Masked Single-Port Synchronous Memory

This block is a synthesizable single-port memory of 1024 words by 32 bits. Address, read/write control, chip enable, the 32 bit-enables and the 32 data-in bits are all captured on the rising clock edge. A single control pin picks the direction: high reads, low writes. A write stores only the data bits whose bit-enable is high. The other bits of the word keep their old contents.

Data-in and data-out are separate buses. After a read edge, the output shows the addressed word. After a write edge, it shows the full data-in word being written. In every other cycle the output holds its previous value. Two inputs block the array entirely: a test-mode input and a wordline-off input. While either is high, no cell is read or written and the output does not move.

The storage is split into byte-wide lanes. Each lane is written only when its slice of the mask is non-zero. The data-out register is the only state with a reset. The array contents are undefined until they are written.

Top module: `sram_bitmask_sp`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros.
- R2: A cycle is active when `en`=1, `tm`=0 and `wloff`=0. In an active cycle with `rw`=1 (read), `dout` holds the word stored at `addr` right after that clock edge, and `din` and `ben` have no effect.
- R3: In an active cycle with `rw`=0 (write), each array bit i takes `din[i]` where `ben[i]`=1 and keeps its old value where `ben[i]`=0.
- R4: In an active write cycle where `ben` has at least one bit set, `dout` shows all 32 bits of `din` right after the edge, whatever the mask.
- R5: An active write cycle with `ben` all zero changes neither the array nor `dout`.
- R6: While `en`=0, the array and `dout` are unchanged.
- R7: While `tm`=1, the array and `dout` are unchanged, whatever the other inputs are.
- R8: While `wloff`=1, no array word is read or written, and `dout` is unchanged.
- R9: Each of the 1024 values of the 10-bit `addr` selects its own word, with no aliasing between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Chip enable, active high |
| tm | input | 1 | Test-mode block; high suppresses normal operation |
| wloff | input | 1 | Wordline-off; high suppresses array access |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 10 | Word address |
| ben | input | 32 | Per-bit write enables, active high |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, or write data during a write |

## Verification
The assertions assume that every input is at a known 0/1 level at each sampled edge. They also assume that `rst_n` is held low across at least one edge before any operation is checked. The bench meets both by driving all inputs to defined values from time zero, and by changing them only one time unit after a rising edge. Reads in the bench target only addresses that were written earlier in the run. This keeps undefined array contents out of every compared value and out of every data-out check.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic              tm,
  input  logic              wloff,
  input  logic              rw,
  input  logic [DATA_W-1:0] ben,
  output sram_op_e          op
);
  logic active;
  assign active = en & ~tm & ~wloff;

  always_comb begin
    op = OP_IDLE;
    if (active) begin
      if (rw)        op = OP_READ;
      else if (|ben) op = OP_WRITE;
    end
  end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  sram_op_e          op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ben,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] msk, wd, old;
    logic              lane_we;

    assign msk     = ben[g*LANE_W +: LANE_W];
    assign wd      = din[g*LANE_W +: LANE_W];
    assign old     = cells[addr];
    assign lane_we = (op == OP_WRITE) && (|msk);

    always_ff @(posedge clk) begin
      if (lane_we) cells[addr] <= (old & ~msk) | (wd & msk);
    end

    assign rword[g*LANE_W +: LANE_W] = old;
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_op_e          op,
  input  logic [DATA_W-1:0] rword,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else begin
      case (op)
        OP_READ:  dout <= rword;
        OP_WRITE: dout <= din;
        default:  dout <= dout;
      endcase
    end
  end
endmodule

// File: rtl/sram_bitmask_sp.sv
module sram_bitmask_sp
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tm,
  input  logic              wloff,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ben,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  sram_op_e          op;
  logic [DATA_W-1:0] rword;

  sram_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .en(en), .tm(tm), .wloff(wloff), .rw(rw), .ben(ben), .op(op)
  );

  sram_lane_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_bank (
    .clk(clk), .op(op), .addr(addr), .ben(ben), .din(din), .rword(rword)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .op(op), .rword(rword), .din(din), .dout(dout)
  );

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> dout == '0);
  p_write_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tm && !wloff && !rw && (ben != '0)) |=> dout == $past(din));
  p_nomask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tm && !wloff && !rw && (ben == '0)) |=> $stable(dout));
  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));
  p_test_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tm |=> $stable(dout));
  p_wloff_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wloff |=> $stable(dout));
endmodule

// File: tb/sim_sram_bitmask_sp.sv
`timescale 1ns/1ps
module sim_sram_bitmask_sp;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, tm = 1'b0, wloff = 1'b0, rw = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] ben = '0, din = '0;
  logic [DW-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] shadow [N];
  logic [DW-1:0] exp_q = '0;

  always #2 clk = ~clk;

  sram_bitmask_sp u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .tm(tm), .wloff(wloff), .rw(rw),
    .addr(addr), .ben(ben), .din(din), .dout(dout)
  );

  function automatic logic [DW-1:0] hsh(input int a, input int salt);
    logic [DW-1:0] v;
    v = DW'(a) * 32'h9E3779B1 + DW'(salt) * 32'h85EBCA6B;
    return v ^ (v >> 13) ^ 32'h5A5A_3C3C;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle, model it, check dout one time unit after the edge
  task automatic cyc(input string req, input logic e, input logic t, input logic w,
                     input logic r, input int a, input logic [DW-1:0] m,
                     input logic [DW-1:0] d);
    en = e; tm = t; wloff = w; rw = r; addr = AW'(a); ben = m; din = d;
    if (e && !t && !w) begin
      if (r) exp_q = shadow[a];
      else if (m != '0) begin
        shadow[a] = (shadow[a] & ~m) | (d & m);
        exp_q = d;
      end
    end
    @(posedge clk);
    #1;
    chk(req, dout, exp_q);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", dout, '0);
    rst_n = 1'b1;

    // R9 R4: fill every word with a full mask
    for (int a = 0; a < N; a++) cyc("R4_R9", 1, 0, 0, 0, a, '1, hsh(a, 1));
    // R2 R9: read every word back with junk on din/ben
    for (int a = 0; a < N; a++) cyc("R2_R9", 1, 0, 0, 1, a, hsh(a, 7), ~hsh(a, 3));
    // R3 R4: masked writes then read-back
    for (int a = 0; a < N; a += 3) cyc("R3_R4", 1, 0, 0, 0, a, hsh(a, 11) | 32'h1, hsh(a, 5));
    for (int a = 0; a < N; a += 3) cyc("R3", 1, 0, 0, 1, a, '0, '0);
    // single-bit masks across every bit position
    for (int b = 0; b < DW; b++) cyc("R3_R4", 1, 0, 0, 0, 40 + b, DW'(1) << b, ~shadow[40 + b]);
    for (int b = 0; b < DW; b++) cyc("R3", 1, 0, 0, 1, 40 + b, '0, '0);
    // R5: zero mask is idle
    for (int a = 100; a < 132; a++) begin
      cyc("R5", 1, 0, 0, 0, a, '0, hsh(a, 99));
      cyc("R5", 1, 0, 0, 1, a, '0, '0);
    end
    // R6 R7 R8: blocked cycles, both directions, then read-back
    for (int a = 200; a < 232; a++) begin
      cyc("R6", 0, 0, 0, 0, a, '1, hsh(a, 21));
      cyc("R6", 0, 0, 0, 1, a + 1, '0, '0);
      cyc("R7", 1, 1, 0, 0, a, '1, hsh(a, 22));
      cyc("R7", 1, 1, 0, 1, a + 2, '0, '0);
      cyc("R8", 1, 0, 1, 0, a, '1, hsh(a, 23));
      cyc("R8", 1, 0, 1, 1, a + 3, '0, '0);
      cyc("R6_R7_R8", 1, 0, 0, 1, a, '0, '0);
    end
    // R1: reset mid-run clears dout
    rst_n = 1'b0;
    #1;
    chk("R1", dout, '0);
    exp_q = '0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc("R1_R2", 1, 0, 0, 1, 5, '0, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule